// File: doc/BRIEF.md
# Ternary Reversible Gate Evaluator

This block evaluates one ternary reversible gate per transaction. Every trit travels as a two-bit code. A transaction carries an opcode, a transform selector and up to four input trits (A, B, C, D). The block returns up to four output trits (P, Q, R, S) and an error flag. All sums and products are taken modulo 3. The supported gates are:

- a controlled single-trit shift;
- the ternary Feynman gate;
- a modified Fredkin gate that exchanges two trits based on a comparison;
- the ternary Peres gate;
- the two-input modified Peres gate.

Transactions enter on a valid/ready input stream. Results leave on a valid/ready output stream through one register stage. An input beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the output on the next cycle. The output stage holds one result. `in_ready` is high when that stage is empty, or when the result it holds is being taken in the same cycle. So a new beat can be accepted in the same cycle that the old result drains. While the downstream side holds `out_ready` low, the result stays frozen on the output pins and `in_ready` drops.

Top module: `tgate_eval`

## Requirements
- R1: Trit codes are 2'b00 = 0, 2'b01 = 1 and 2'b10 = 2. If the code 2'b11 appears on any input that the selected gate uses, the result has `out_err` = 1 and all four output trits equal to 2'b00.
- R2: Opcode 3'b000 (controlled shift) gives P = A. Q is the selected transform of B when A = 2, and Q = B otherwise. R and S are 0. This gate uses A and B.
- R3: The transform selector `in_xf` picks the transform applied by the controlled shift: 3'b000 adds 1, 3'b001 adds 2, 3'b010 swaps values 1 and 2, 3'b011 swaps 0 and 1, 3'b100 swaps 0 and 2, and 3'b101 to 3'b111 leave the trit unchanged.
- R4: Opcode 3'b001 (Feynman gate) gives P = A, Q = (A + B) mod 3, and R = S = 0. With B = 0, P and Q both equal A (fan-out). This gate uses A and B.
- R5: Opcode 3'b010 (modified Fredkin gate) gives P = A and Q = B. When A < B, R = C and S = D. Otherwise R = D and S = C. This gate uses all four inputs.
- R6: Opcode 3'b011 (Peres gate) gives P = A, Q = (A + B) mod 3, R = (A·B + C) mod 3, and S = 0. This gate uses A, B and C.
- R7: Opcode 3'b100 (modified Peres gate) gives P = A, Q = (A + B) mod 3, and R = S = 0. This gate uses A and B.
- R8: Opcodes 3'b101 to 3'b111 give all-zero trits with `out_err` = 0, whatever the input codes. For every opcode, the inputs that the gate does not use have no effect on the result, even when they carry 2'b11.
- R9: For each gate, and for each transform of the controlled shift, distinct legal input combinations map to distinct output combinations.
- R10: A beat accepted on an edge appears as `out_valid` = 1 after that edge. `in_ready` = 1 exactly when `out_valid` = 0 or `out_ready` = 1. `out_valid` never rises without an accepted beat.
- R11: While `out_valid` = 1 and `out_ready` = 0, the output trits and `out_err` are held unchanged into the next cycle, and `out_valid` stays 1.
- R12: While reset is applied and after it is released, `out_valid` = 0 until a beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An input beat is present |
| in_ready | output | 1 | The block can take an input beat |
| in_op | input | 3 | Gate opcode |
| in_xf | input | 3 | Transform selector for the controlled shift |
| in_a | input | 2 | Trit A (control trit) |
| in_b | input | 2 | Trit B |
| in_c | input | 2 | Trit C |
| in_d | input | 2 | Trit D |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | Downstream takes the result |
| out_p | output | 2 | Trit P |
| out_q | output | 2 | Trit Q |
| out_r | output | 2 | Trit R |
| out_s | output | 2 | Trit S |
| out_err | output | 1 | An illegal code was seen on a used input |

## Verification
The two functions that can fall in the same cycle are draining the held result and accepting a new beat. This happens when the output stage is full and `out_ready` and `in_valid` are both high. Back-to-back beats with `out_ready` held high provoke it, and so do long random runs that toggle both handshakes. The bench's behavioural queue model predicts `in_ready`, `out_valid` and each result. Any beat lost or duplicated during a simultaneous drain-and-fill shows up as a mismatch against that model. Stalls that overlap illegal codes or unknown opcodes are judged the same way, and the held result must match across the whole stall.

// File: rtl/tern_pkg.sv
package tern_pkg;
  localparam int TRIT_W = 2;
  localparam int OP_W   = 3;
  localparam int XF_W   = 3;
  localparam int N_TRIT = 4;

  typedef logic [TRIT_W-1:0] trit_t;

  localparam trit_t T_ZERO = 2'b00;
  localparam trit_t T_ONE  = 2'b01;
  localparam trit_t T_TWO  = 2'b10;
  localparam trit_t T_BAD  = 2'b11;

  typedef enum logic [OP_W-1:0] {
    OP_CSHIFT = 3'd0,
    OP_FEYN   = 3'd1,
    OP_MFRED  = 3'd2,
    OP_PERES  = 3'd3,
    OP_MPERES = 3'd4
  } gate_op_e;

  typedef enum logic [XF_W-1:0] {
    XF_ADD1  = 3'd0,
    XF_ADD2  = 3'd1,
    XF_SW12  = 3'd2,
    XF_SW01  = 3'd3,
    XF_SW02  = 3'd4
  } xform_e;

  typedef struct packed {
    logic  err;
    trit_t p;
    trit_t q;
    trit_t r;
    trit_t s;
  } gate_res_t;

  localparam int RES_W = 1 + N_TRIT * TRIT_W;

  // modulo-3 sum of two legal trits
  function automatic trit_t t_add(input trit_t x, input trit_t y);
    logic [TRIT_W:0] sum;
    sum = {1'b0, x} + {1'b0, y};
    if (sum >= 3'd3) sum = sum - 3'd3;
    return sum[TRIT_W-1:0];
  endfunction

  // modulo-3 product of two legal trits (raw product is 0, 1, 2 or 4)
  function automatic trit_t t_mul(input trit_t x, input trit_t y);
    logic [2*TRIT_W-1:0] prod;
    prod = {2'b00, x} * {2'b00, y};
    if (prod == 4'd4) return T_ONE;
    return prod[TRIT_W-1:0];
  endfunction
endpackage

// File: rtl/tern_xform.sv
module tern_xform
  import tern_pkg::*;
(
  input  trit_t           din,
  input  logic [XF_W-1:0] sel,
  output trit_t           dout
);
  always_comb begin
    case (xform_e'(sel))
      XF_ADD1: dout = t_add(din, T_ONE);
      XF_ADD2: dout = t_add(din, T_TWO);
      XF_SW12: dout = (din == T_ONE) ? T_TWO : (din == T_TWO) ? T_ONE : din;
      XF_SW01: dout = (din == T_ZERO) ? T_ONE : (din == T_ONE) ? T_ZERO : din;
      XF_SW02: dout = (din == T_ZERO) ? T_TWO : (din == T_TWO) ? T_ZERO : din;
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/tern_gate_core.sv
module tern_gate_core
  import tern_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [XF_W-1:0] xf,
  input  trit_t           a,
  input  trit_t           b,
  input  trit_t           c,
  input  trit_t           d,
  output gate_res_t       res
);
  logic [N_TRIT-1:0] used;
  logic [N_TRIT-1:0] bad_code;
  trit_t             trits [N_TRIT];
  trit_t             shifted;
  trit_t             sum_ab;
  trit_t             prod_ab;
  logic              a_lt_b;
  gate_res_t         g_cs, g_fy, g_fr, g_pe, g_mp, g_sel;

  assign trits[0] = a;
  assign trits[1] = b;
  assign trits[2] = c;
  assign trits[3] = d;

  for (genvar i = 0; i < N_TRIT; i++) begin : g_bad
    assign bad_code[i] = (trits[i] == T_BAD);
  end

  // which inputs each gate reads: bit0 = A .. bit3 = D
  always_comb begin
    case (gate_op_e'(op))
      OP_CSHIFT, OP_FEYN, OP_MPERES: used = 4'b0011;
      OP_PERES:                      used = 4'b0111;
      OP_MFRED:                      used = 4'b1111;
      default:                       used = 4'b0000;
    endcase
  end

  tern_xform u_xf (
    .din  (b),
    .sel  (xf),
    .dout (shifted)
  );

  assign sum_ab  = t_add(a, b);
  assign prod_ab = t_mul(a, b);
  assign a_lt_b  = (a < b);

  always_comb begin
    g_cs     = '0;
    g_cs.p   = a;
    g_cs.q   = (a == T_TWO) ? shifted : b;
  end

  always_comb begin
    g_fy     = '0;
    g_fy.p   = a;
    g_fy.q   = sum_ab;
  end

  always_comb begin
    g_fr     = '0;
    g_fr.p   = a;
    g_fr.q   = b;
    g_fr.r   = a_lt_b ? c : d;
    g_fr.s   = a_lt_b ? d : c;
  end

  always_comb begin
    g_pe     = '0;
    g_pe.p   = a;
    g_pe.q   = sum_ab;
    g_pe.r   = t_add(prod_ab, c);
  end

  always_comb begin
    g_mp     = '0;
    g_mp.p   = a;
    g_mp.q   = sum_ab;
  end

  always_comb begin
    case (gate_op_e'(op))
      OP_CSHIFT: g_sel = g_cs;
      OP_FEYN:   g_sel = g_fy;
      OP_MFRED:  g_sel = g_fr;
      OP_PERES:  g_sel = g_pe;
      OP_MPERES: g_sel = g_mp;
      default:   g_sel = '0;
    endcase
  end

  always_comb begin
    if (|(used & bad_code)) begin
      res     = '0;
      res.err = 1'b1;
    end else begin
      res = g_sel;
    end
  end
endmodule

// File: rtl/tern_out_reg.sv
module tern_out_reg #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/tgate_eval.sv
module tgate_eval
  import tern_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [2:0] in_op,
  input  logic [2:0] in_xf,
  input  logic [1:0] in_a,
  input  logic [1:0] in_b,
  input  logic [1:0] in_c,
  input  logic [1:0] in_d,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] out_p,
  output logic [1:0] out_q,
  output logic [1:0] out_r,
  output logic [1:0] out_s,
  output logic       out_err
);
  gate_res_t comb_res;
  gate_res_t held_res;

  tern_gate_core u_core (
    .op  (in_op),
    .xf  (in_xf),
    .a   (in_a),
    .b   (in_b),
    .c   (in_c),
    .d   (in_d),
    .res (comb_res)
  );

  tern_out_reg #(.W(RES_W)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (comb_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (held_res)
  );

  assign out_p   = held_res.p;
  assign out_q   = held_res.q;
  assign out_r   = held_res.r;
  assign out_s   = held_res.s;
  assign out_err = held_res.err;
endmodule

// File: rtl/tgate_eval_chk.sv
module tgate_eval_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [2:0] in_op,
  input logic [2:0] in_xf,
  input logic [1:0] in_a,
  input logic [1:0] in_b,
  input logic [1:0] in_c,
  input logic [1:0] in_d,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_p,
  input logic [1:0] out_q,
  input logic [1:0] out_r,
  input logic [1:0] out_s,
  input logic       out_err
);
  a_r1_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_p == 2'b00 && out_q == 2'b00 && out_r == 2'b00 && out_s == 2'b00));

  a_r1_no_bad_out: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_p != 2'b11 && out_q != 2'b11 && out_r != 2'b11 && out_s != 2'b11));

  a_r4_fanout: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 3'b001 && in_a != 2'b11 && in_b == 2'b00)
      |=> (out_p == $past(in_a) && out_q == $past(in_a) && !out_err));

  a_r5_pass_low: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 3'b010 && in_a != 2'b11 && in_b != 2'b11 &&
     in_c != 2'b11 && in_d != 2'b11 && in_a < in_b)
      |=> (out_r == $past(in_c) && out_s == $past(in_d)));

  a_r8_unknown_op: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op > 3'b100)
      |=> (!out_err && out_p == 2'b00 && out_q == 2'b00 && out_r == 2'b00 && out_s == 2'b00));

  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    ((!out_valid || out_ready) && !in_valid) |=> !out_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready)
      |=> (out_valid && $stable(out_p) && $stable(out_q) && $stable(out_r) &&
           $stable(out_s) && $stable(out_err)));
endmodule

bind tgate_eval tgate_eval_chk u_chk (.*);

// File: tb/sim_tgate_eval.sv
module sim_tgate_eval;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_op = '0;
  logic [2:0] in_xf = '0;
  logic [1:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [1:0] out_p, out_q, out_r, out_s;
  logic       out_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  tgate_eval u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_xf(in_xf), .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_p(out_p), .out_q(out_q), .out_r(out_r), .out_s(out_s), .out_err(out_err)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  logic [8:0] mq[$];
  string      mtag[$];
  bit         stalled = 1'b0;
  bit         collecting = 1'b0;
  bit         seen[logic [8:0]];

  // behavioural single-trit transform, values as integers 0..2
  function automatic int xf_ref(int x, int v);
    case (x)
      0: return (v + 1) % 3;
      1: return (v + 2) % 3;
      2: return (v == 0) ? 0 : 3 - v;
      3: return (v == 2) ? 2 : 1 - v;
      4: return (v == 1) ? 1 : 2 - v;
      default: return v;
    endcase
  endfunction

  // result packing: [8] err, [7:6] P, [5:4] Q, [3:2] R, [1:0] S
  function automatic logic [8:0] ref_eval(int op, int x, int a, int b, int c, int d);
    int p, q, r, s;
    bit bad;
    p = 0; q = 0; r = 0; s = 0;
    if (op > 4) return 9'h000;
    bad = (a == 3) || (b == 3);
    if (op == 3) bad = bad || (c == 3);
    if (op == 2) bad = bad || (c == 3) || (d == 3);
    if (bad) return 9'h100;
    p = a;
    case (op)
      0: q = (a == 2) ? xf_ref(x, b) : b;
      1, 4: q = (a + b) % 3;
      2: begin q = b; r = (a < b) ? c : d; s = (a < b) ? d : c; end
      3: begin q = (a + b) % 3; r = (a * b + c) % 3; end
      default: ;
    endcase
    return {1'b0, 2'(p), 2'(q), 2'(r), 2'(s)};
  endfunction

  function automatic string tag_of(int op, logic [8:0] e);
    if (e[8]) return "R1";
    case (op)
      0: return "R2 R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at the falling edge, compare registered outputs, advance the model
  task automatic step(bit iv, int op, int x, int a, int b, int c, int d, bit ordy);
    bit         mready;
    bit         mvalid;
    logic [8:0] got;
    @(negedge clk);
    in_valid = iv; in_op = 3'(op); in_xf = 3'(x);
    in_a = 2'(a); in_b = 2'(b); in_c = 2'(c); in_d = 2'(d);
    out_ready = ordy;
    #1;
    mvalid = (mq.size() != 0);
    mready = !mvalid || ordy;
    got = {out_err, out_p, out_q, out_r, out_s};
    check(in_ready === mready, "R10", "in_ready", 9'(in_ready), 9'(mready));
    check(out_valid === mvalid, "R10 R12", "out_valid", 9'(out_valid), 9'(mvalid));
    if (mvalid && out_valid === 1'b1)
      check(got === mq[0], stalled ? {"R11 ", mtag[0]} : mtag[0], "result", got, mq[0]);
    stalled = mvalid && !ordy;
    if (mvalid && ordy) begin
      if (collecting) seen[got] = 1'b1;
      void'(mq.pop_front());
      void'(mtag.pop_front());
    end
    if (iv && mready) begin
      logic [8:0] e;
      e = ref_eval(op, x, a, b, c, d);
      mq.push_back(e);
      mtag.push_back(tag_of(op, e));
    end
  endtask

  // R9: sweep all legal inputs of one gate and count distinct outputs
  task automatic rev_group(int op, int x, int nc, int nd);
    int n;
    seen.delete();
    collecting = 1'b1;
    n = 0;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < nc; c++)
          for (int d = 0; d < nd; d++) begin
            step(1'b1, op, x, a, b, c, d, 1'b1);
            n++;
          end
    step(1'b0, 0, 0, 0, 0, 0, 0, 1'b1);
    step(1'b0, 0, 0, 0, 0, 0, 0, 1'b1);
    collecting = 1'b0;
    check(seen.num() == n, "R9", "distinct outputs", 9'(seen.num()), 9'(n));
  endtask

  function automatic int rnd_code();
    return (($urandom % 8) == 0) ? 3 : int'($urandom % 3);
  endfunction

  initial begin
    // R12: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R12", "out_valid in reset", 9'(out_valid), 9'h0);
    rst_n = 1'b1;
    step(1'b0, 0, 0, 0, 0, 0, 0, 1'b0);

    // R9 with R2..R7 content: exhaustive legal sweeps
    for (int x = 0; x < 5; x++) rev_group(0, x, 1, 1);
    rev_group(1, 0, 1, 1);
    rev_group(2, 0, 3, 3);
    rev_group(3, 0, 3, 1);
    rev_group(4, 0, 1, 1);

    // R3: identity selectors
    for (int x = 5; x < 8; x++)
      for (int b = 0; b < 3; b++) step(1'b1, 0, x, 2, b, 0, 0, 1'b1);

    // R8: illegal codes on unused inputs, unknown opcodes
    step(1'b1, 1, 0, 2, 1, 3, 3, 1'b1);
    step(1'b1, 0, 7, 2, 2, 3, 3, 1'b1);
    step(1'b1, 3, 0, 1, 2, 2, 3, 1'b1);
    step(1'b1, 5, 0, 3, 3, 3, 3, 1'b1);
    step(1'b1, 6, 1, 1, 2, 0, 1, 1'b1);
    step(1'b1, 7, 2, 2, 0, 1, 3, 1'b1);

    // R1: illegal codes on used inputs
    step(1'b1, 1, 0, 3, 0, 0, 0, 1'b1);
    step(1'b1, 2, 0, 1, 2, 0, 3, 1'b1);
    step(1'b1, 3, 0, 1, 1, 3, 0, 1'b1);
    step(1'b1, 0, 0, 2, 3, 0, 0, 1'b1);

    // R11: stall with a new beat offered, then drain and fill together
    step(1'b1, 3, 0, 2, 2, 1, 0, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b1, 2, 0, 2, 1, 0, 1, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b1, 1, 0, i % 3, (i + 1) % 3, 0, 0, 1'b1);
    step(1'b0, 0, 0, 0, 0, 0, 0, 1'b1);

    // random traffic with back-pressure
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, int'($urandom % 8), int'($urandom % 8),
           rnd_code(), rnd_code(), rnd_code(), rnd_code(), ($urandom % 3) != 0);
    step(1'b0, 0, 0, 0, 0, 0, 0, 1'b1);
    step(1'b0, 0, 0, 0, 0, 0, 0, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule